// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

This block watches a free-running timer count and compares it, every clock, against a compare value that software loads one byte at a time. When the count arrives at the compare value, the block carries out the action picked by a four-bit mode register. It can raise the compare output latch, lower it, raise only the interrupt flag, or fire a trigger event. The trigger event resets the timer and requests an ADC conversion.

In trigger mode the compare value works as a programmable period for the timer. The timer, the converter and the interrupt controller sit outside this block and are reached only through the pulse and flag outputs. The output pin is driven only while its direction input selects output. The compare output latch is private to this block; it is not the port data latch.

Top module: `cmp_trig_unit`

## Requirements
- R1: The 16-bit compare value is loaded through the byte write port: when `cr_wr` is high, `cr_wdata` goes to the high byte if `cr_byte_sel` is 1 and to the low byte if it is 0. A match exists when `tmr_count` equals the full compare value.
- R2: With mode 4'b1000 a match sets the compare latch to 1. With mode 4'b1001 a match clears it to 0. The latch is visible on `pin_out` one clock after the match edge.
- R3: A match in any of the modes 4'b1000, 4'b1001, 4'b1010 or 4'b1011 sets `cmp_flag`. The flag stays set until `flag_clr` is high at a clock edge that has no match. When a clear and a match arrive in the same cycle, the flag stays set. Any other mode value sets no flag.
- R4: With mode 4'b1010 a match sets only the flag. The compare latch, `tmr_reset` and `adc_start` keep their levels.
- R5: With mode 4'b1011 a match makes `tmr_reset` high for exactly one cycle, in the cycle after the match edge. `adc_start` is pulsed in the same cycle only if `adc_enable` was high at the match edge.
- R6: Only a new match triggers an action, meaning count equal to the compare value after a cycle in which they were not equal. If the count stays equal to the compare value, there is no further latch change, flag set or pulse.
- R7: A write of 4'b0000 to the mode register (`mode_wr` high) clears the compare latch. Any other mode write leaves the latch untouched. In particular, switching between 4'b1000 and 4'b1001 without a match does not change `pin_out`.
- R8: `pin_oe` equals `pin_dir_out`. `pin_out` shows the latch while `pin_oe` is 1 and is 0 while `pin_oe` is 0.
- R9: After reset the mode is 4'b0000, the compare value is 0, and the latch, flag, `tmr_reset` and `adc_start` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | New mode value |
| cr_wr | input | 1 | Compare register byte write strobe |
| cr_byte_sel | input | 1 | Byte select: 1 high, 0 low |
| cr_wdata | input | 8 | Compare byte data |
| tmr_count | input | 16 | Current timer count |
| adc_enable | input | 1 | ADC enabled; gates the conversion request |
| pin_dir_out | input | 1 | Pin direction: 1 selects output |
| flag_clr | input | 1 | Software clear of the compare flag |
| tmr_reset | output | 1 | One-cycle timer reset pulse |
| adc_start | output | 1 | One-cycle conversion start pulse |
| cmp_flag | output | 1 | Compare interrupt flag |
| pin_out | output | 1 | Compare pin data |
| pin_oe | output | 1 | Compare pin output enable |

## Verification
The bench holds the timer count at the compare value for several clocks. A design that acts on the level of the match instead of its edge would set the flag again after software cleared it, or would repeat the timer reset. The bench switches the mode from clear to set without a match, which catches a latch that inverts or copies the mode bit. It also lands a flag clear on the same cycle as a match, which catches a design that lets the clear win. The bench checks a trigger with the converter disabled, where a wrongly gated request would still start a conversion. It checks that a zero mode write clears the latch and that a disabled pin reads 0.

// File: rtl/cmp_trig_pkg.sv
// Package: shared mode codes and helpers for the compare unit.
package cmp_trig_pkg;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MD_OFF  = 4'b0000,
        MD_SET  = 4'b1000,
        MD_CLR  = 4'b1001,
        MD_SWI  = 4'b1010,
        MD_TRIG = 4'b1011
    } cmp_mode_e;

    // True when the mode value is one of the four compare actions.
    function automatic logic is_cmp_mode(input logic [MODE_W-1:0] m);
        return (m == MD_SET) || (m == MD_CLR) || (m == MD_SWI) || (m == MD_TRIG);
    endfunction
endpackage

// File: rtl/cmp_value_reg.sv
// Compare value register built from byte lanes.
// Assumes TW is a multiple of BW; lane index 0 is the least significant byte.
module cmp_value_reg #(
    parameter int TW = 16,
    parameter int BW = 8,
    localparam int NLANE = TW / BW,
    localparam int SELW = (NLANE > 1) ? $clog2(NLANE) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [SELW-1:0] sel,
    input  logic [BW-1:0]   wdata,
    output logic [TW-1:0]   value
);
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        // Load one byte lane when it is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                value[g*BW +: BW] <= '0;
            else if (wr && (sel == SELW'(g)))
                value[g*BW +: BW] <= wdata;
        end
    end
endmodule

// File: rtl/cmp_match_det.sv
// Match detector: compares count with the compare value and reports
// only the first cycle of equality (a new match).
module cmp_match_det #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] count,
    input  logic [TW-1:0] value,
    output logic          new_match
);
    logic eq, eq_q;

    // Equality of count and compare value this cycle.
    always_comb eq = (count == value);

    // Remember last cycle's equality to find the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq;
    end

    // A match is new when equality was absent one cycle earlier.
    always_comb new_match = eq && !eq_q;
endmodule

// File: rtl/cmp_action_ctl.sv
// Action controller: holds the mode register, the compare latch, the flag
// and the trigger pulses. Assumes new_match is a single-cycle strobe.
module cmp_action_ctl
    import cmp_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              new_match,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              adc_enable,
    input  logic              flag_clr,
    output logic              latch,
    output logic              flag,
    output logic              tmr_reset,
    output logic              adc_start
);
    logic [MODE_W-1:0] mode_q;
    logic              act;

    // Mode register, software writable.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MD_OFF;
        else if (mode_wr) mode_q <= mode_wdata;
    end

    // A match counts only in a compare mode.
    always_comb act = new_match && is_cmp_mode(mode_q);

    // Compare latch: a zero mode write wins, then set/clear on match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch <= 1'b0;
        else if (mode_wr && (mode_wdata == MD_OFF))
            latch <= 1'b0;
        else if (act && (mode_q == MD_SET))
            latch <= 1'b1;
        else if (act && (mode_q == MD_CLR))
            latch <= 1'b0;
    end

    // Sticky flag: a match set takes priority over the software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (act)      flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    // Single-cycle trigger pulses in the cycle after the match edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_reset <= 1'b0;
            adc_start <= 1'b0;
        end else begin
            tmr_reset <= act && (mode_q == MD_TRIG);
            adc_start <= act && (mode_q == MD_TRIG) && adc_enable;
        end
    end
endmodule

// File: rtl/cmp_trig_unit.sv
// Top of the timer compare unit. Joins the compare register, the match
// detector and the action controller, and drives the pin enable.
// Assumes tmr_count is synchronous to clk.
module cmp_trig_unit
    import cmp_trig_pkg::*;
#(
    parameter int TW = 16,
    parameter int BW = 8,
    localparam int NLANE = TW / BW,
    localparam int SELW = (NLANE > 1) ? $clog2(NLANE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              cr_wr,
    input  logic [SELW-1:0]   cr_byte_sel,
    input  logic [BW-1:0]     cr_wdata,
    input  logic [TW-1:0]     tmr_count,
    input  logic              adc_enable,
    input  logic              pin_dir_out,
    input  logic              flag_clr,
    output logic              tmr_reset,
    output logic              adc_start,
    output logic              cmp_flag,
    output logic              pin_out,
    output logic              pin_oe
);
    logic [TW-1:0] cmp_value;
    logic          new_match;
    logic          latch;

    cmp_value_reg #(.TW(TW), .BW(BW)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr(cr_wr), .sel(cr_byte_sel),
        .wdata(cr_wdata), .value(cmp_value)
    );

    cmp_match_det #(.TW(TW)) u_det (
        .clk(clk), .rst_n(rst_n), .count(tmr_count), .value(cmp_value),
        .new_match(new_match)
    );

    cmp_action_ctl u_act (
        .clk(clk), .rst_n(rst_n), .new_match(new_match),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .adc_enable(adc_enable), .flag_clr(flag_clr),
        .latch(latch), .flag(cmp_flag),
        .tmr_reset(tmr_reset), .adc_start(adc_start)
    );

    // Pin drive: enabled by direction, data masked while disabled.
    always_comb begin
        pin_oe  = pin_dir_out;
        pin_out = pin_dir_out & latch;
    end
endmodule

// File: rtl/cmp_trig_unit_chk.sv
// Checker for cmp_trig_unit, attached by bind. Observes ports only.
module cmp_trig_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic flag_clr,
    input logic tmr_reset,
    input logic adc_start,
    input logic cmp_flag,
    input logic pin_out,
    input logic pin_oe
);
    // R5: the timer reset never lasts two cycles.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_reset |=> !tmr_reset);

    // R5: a conversion request only comes with a timer reset.
    a_r5_adc_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> tmr_reset);

    // R3: the flag holds unless software clears it.
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !flag_clr) |=> cmp_flag);

    // R3: a trigger pulse always comes with a raised flag.
    a_r3_flag_on_trig: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_reset |-> cmp_flag);

    // R8: a disabled pin never shows a high level.
    a_r8_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !pin_out);
endmodule

bind cmp_trig_unit cmp_trig_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr), .tmr_reset(tmr_reset),
    .adc_start(adc_start), .cmp_flag(cmp_flag), .pin_out(pin_out),
    .pin_oe(pin_oe)
);

// File: tb/cmp_trig_unit_test.sv
module cmp_trig_unit_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_wr = 1'b0;
    logic [3:0] mode_wdata = 4'b0;
    logic cr_wr = 1'b0;
    logic [0:0] cr_byte_sel = 1'b0;
    logic [7:0] cr_wdata = 8'h0;
    logic [15:0] tmr_count = 16'h0;
    logic adc_enable = 1'b0;
    logic pin_dir_out = 1'b1;
    logic flag_clr = 1'b0;
    logic tmr_reset, adc_start, cmp_flag, pin_out, pin_oe;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    cmp_trig_unit uut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .cr_wr(cr_wr), .cr_byte_sel(cr_byte_sel), .cr_wdata(cr_wdata),
        .tmr_count(tmr_count), .adc_enable(adc_enable),
        .pin_dir_out(pin_dir_out), .flag_clr(flag_clr),
        .tmr_reset(tmr_reset), .adc_start(adc_start), .cmp_flag(cmp_flag),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Vector: {mode[24:21], cmp[20:5], adc_en[4], pin[3], flag[2], tres[1], adc[0]}
    localparam logic [24:0] VEC [8] = '{
        {4'b1000, 16'h1234, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {4'b1001, 16'hABCD, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {4'b1000, 16'h00FF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {4'b1010, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {4'b1011, 16'h0400, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        {4'b1011, 16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {4'b0101, 16'h5555, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'b1001, 16'h0001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
        cycles++;
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic [3:0] m);
        mode_wr = 1'b1; mode_wdata = m; tick(); mode_wr = 1'b0;
    endtask

    task automatic load_cmp(input logic [15:0] v);
        cr_wr = 1'b1;
        cr_byte_sel = 1'b1; cr_wdata = v[15:8]; tick();
        cr_byte_sel = 1'b0; cr_wdata = v[7:0];  tick();
        cr_wr = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) tick();
        // R9: reset state
        check("R9 pin", {15'b0, pin_out}, 16'h0);
        check("R9 flag", {15'b0, cmp_flag}, 16'h0);
        check("R9 pulses", {14'b0, tmr_reset, adc_start}, 16'h0);
        rst_n = 1'b1;
        tick();
        check("R9 no action on reset match", {15'b0, cmp_flag}, 16'h0);

        // Table walk: R1 R2 R3 R4 R5
        foreach (VEC[i]) begin
            set_mode(VEC[i][24:21]);
            load_cmp(VEC[i][20:5]);
            adc_enable = VEC[i][4];
            tmr_count = VEC[i][20:5] ^ 16'h0F0F;
            tick();
            clear_flag();
            tmr_count = VEC[i][20:5];
            tick();
            check($sformatf("R1/R2 vec%0d pin", i), {15'b0, pin_out}, {15'b0, VEC[i][3]});
            check($sformatf("R3 vec%0d flag", i), {15'b0, cmp_flag}, {15'b0, VEC[i][2]});
            check($sformatf("R5 vec%0d tres", i), {15'b0, tmr_reset}, {15'b0, VEC[i][1]});
            check($sformatf("R5 vec%0d adc", i), {15'b0, adc_start}, {15'b0, VEC[i][0]});
            tick();
            check($sformatf("R5 vec%0d pulse ends", i), {14'b0, tmr_reset, adc_start}, 16'h0);
        end

        // R6: stalled timer, equality held, no retrigger after clear
        set_mode(4'b1011);
        load_cmp(16'h2222);
        tmr_count = 16'h2221; tick();
        tmr_count = 16'h2222; tick();
        check("R6 first match pulses", {15'b0, tmr_reset}, 16'h1);
        clear_flag();
        for (int k = 0; k < 5; k++) begin
            tick();
            check("R6 held equal no pulse", {15'b0, tmr_reset}, 16'h0);
        end
        check("R6 held equal no flag", {15'b0, cmp_flag}, 16'h0);

        // R3: clear and match in the same cycle keep the flag set
        tmr_count = 16'h2223; tick();
        flag_clr = 1'b1; tmr_count = 16'h2222; tick(); flag_clr = 1'b0;
        check("R3 clear vs match", {15'b0, cmp_flag}, 16'h1);

        // R7: mode change without match keeps the latch
        set_mode(4'b1000);
        load_cmp(16'h3000);
        tmr_count = 16'h3001; tick();
        tmr_count = 16'h3000; tick();
        check("R2 set before switch", {15'b0, pin_out}, 16'h1);
        set_mode(4'b1001);
        check("R7 set->clear no change", {15'b0, pin_out}, 16'h1);
        set_mode(4'b1000);
        check("R7 clear->set no inversion", {15'b0, pin_out}, 16'h1);

        // R8: direction input controls enable and masks data
        pin_dir_out = 1'b0; #1;
        check("R8 oe off", {15'b0, pin_oe}, 16'h0);
        check("R8 pin masked", {15'b0, pin_out}, 16'h0);
        pin_dir_out = 1'b1; #1;
        check("R8 oe on shows latch", {14'b0, pin_oe, pin_out}, 16'h3);

        // R4: software interrupt mode keeps a low latch low too
        set_mode(4'b1001);
        tmr_count = 16'h3001; tick();
        tmr_count = 16'h3000; tick();
        check("R2 clear", {15'b0, pin_out}, 16'h0);
        set_mode(4'b1010);
        tmr_count = 16'h3001; tick();
        tmr_count = 16'h3000; tick();
        check("R4 latch stays low", {15'b0, pin_out}, 16'h0);

        // R7: zero mode write clears the latch
        set_mode(4'b1000);
        tmr_count = 16'h3001; tick();
        tmr_count = 16'h3000; tick();
        check("R7 latch high", {15'b0, pin_out}, 16'h1);
        set_mode(4'b0000);
        check("R7 zero write clears", {15'b0, pin_out}, 16'h0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule